// File: doc/BRIEF.md
# Interrupt Source Delivery Router

This block keeps the settings and live state of a set of interrupt sources. It decides which processor outputs receive each source once that source becomes pending. Every source has two 32-bit registers on a simple single-cycle register bus. The first register holds the mask, priority and vector. The second holds the delivery mode, the input sense and a one-bit-per-CPU destination mask.

A source can be level or edge sensitive. Level sources are pending while the input is high. Edge sources latch pending on a rising input and drop it once they are delivered. A read-only activity flag is set on every delivery. While it is set, the same source cannot be delivered again. A level source clears the flag when its input falls. An edge source clears it when the CPU presentation logic acknowledges that source.

Routing works in one of three ways. If the destination mask names exactly the CPU that last took the source, the source goes to that CPU. Otherwise, in directed mode the source goes to every CPU in the mask. In distributed mode the router searches the mask round-robin, starting after the last CPU served. When several sources are eligible in the same cycle, one is routed per cycle. The output is a registered, one-cycle delivery request carrying a CPU bit vector and the source number.

Top module: `irq_route_top`

## Requirements
- R1: The vector/priority register keeps bit 31 as the source mask, bits 19:16 as the priority and bits 7:0 as the vector. Bit 30 reads back the activity flag, and a write cannot change it. A write takes only the bits under 0x800F00FF, and every other bit reads as zero.
- R2: The destination register keeps bit 31 as the mode (1 = distributed, 0 = directed), bit 30 as the sense (1 = level, 0 = edge) and bits N_CPU-1:0 as the CPU mask. All other bits read as zero. Register word address = 2*source + select, where select 0 is the vector/priority register and select 1 is the destination register.
- R3: After reset, every vector/priority register reads VP_RST (default 0x80000000, masked), every destination register reads DST_RST (default 0x00000001, CPU 0), no request is issued, and the last CPU served is CPU 0.
- R4: A pending source is not delivered while it is masked, while its priority is 0, or while its CPU mask is all zeros. Once the blocking condition is removed, it is delivered.
- R5: A delivery sets the source's activity flag. While the flag is set, the source is not delivered again. An acknowledge (ack_i with ack_src_i naming the source) clears the flag of an edge source.
- R6: For a level source, pending follows the input. Input deassertion clears the activity flag, so the source can be delivered again when the input is reasserted.
- R7: For an edge source, a rising input sets pending and delivery clears it. An input that is held high is therefore delivered only once, even after an acknowledge.
- R8: If the CPU mask equals exactly the last CPU served, only that CPU receives the source, in either mode.
- R9: In directed mode (when R8 does not apply), the request names every CPU set in the mask.
- R10: In distributed mode (when R8 does not apply), the router takes the first CPU in the mask, searching upward from the CPU after the last one served and wrapping at N_CPU. That CPU becomes the last one served.
- R11: A request appears two clock edges after an input rises, and one edge after the register write that makes a pending source eligible. When several sources are eligible, the lowest-numbered source is served first, one per cycle. While dlv_valid_o is low, dlv_cpu_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | SW+1 | Word address: {source, select} |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_i | input | N_SRC | Interrupt source inputs |
| ack_i | input | 1 | Acknowledge strobe from the presentation logic |
| ack_src_i | input | SW | Source being acknowledged |
| dlv_valid_o | output | 1 | Delivery request valid (one cycle) |
| dlv_cpu_o | output | N_CPU | CPUs that receive the request |
| dlv_src_o | output | SW | Source being delivered |

## Verification
A rising input is latched as pending on the first edge, and the request is registered on the second edge. A write that unblocks a pending source yields a request on the edge after the write. Level deassertion clears the activity flag on the next edge, and register readback is available in the same cycle. The bench drives inputs and samples outputs on falling edges and advances an exact number of edges before each comparison. It checks an edge too early for silence, the due edge for the request and the following edge for absence of redelivery.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VP_MASK_BIT  = 31;
  localparam int VP_ACT_BIT   = 30;
  localparam int PRIO_LSB     = 16;
  localparam int PRIO_W       = 4;
  localparam int VEC_W        = 8;
  localparam int DST_MODE_BIT = 31;
  localparam int DST_SENSE_BIT = 30;
  localparam logic [31:0] VP_WR_MASK = 32'h800F_00FF;

  typedef struct packed {
    logic              masked;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } vp_cfg_t;
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_route_pkg::*;
#(
  parameter int          N_CPU   = 4,
  parameter logic [31:0] VP_RST  = 32'h8000_0000,
  parameter logic [31:0] DST_RST = 32'h0000_0001,
  localparam int         CW      = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_i,
  input  logic             we_vp_i,
  input  logic             we_dst_i,
  input  logic [31:0]      wdata_i,
  input  logic             grant_i,
  input  logic             ack_i,
  output logic [31:0]      vp_o,
  output logic [31:0]      dst_o,
  output logic             elig_o,
  output logic             act_o,
  output logic [N_CPU-1:0] tgt_o
);
  vp_cfg_t          cfg_q;
  logic             mode_q, sense_q;
  logic [N_CPU-1:0] dmask_q;
  logic             act_q, pend_q, irq_q;
  logic [CW-1:0]    last_q;

  logic [N_CPU-1:0] last_oh, rr_oh;
  logic [CW-1:0]    rr_idx;
  logic             rr_found, exact;

  always_comb begin
    last_oh = '0;
    last_oh[last_q] = 1'b1;
    exact = (dmask_q == last_oh);
  end

  // round-robin search starting after the last CPU served
  always_comb begin
    rr_oh    = '0;
    rr_idx   = last_q;
    rr_found = 1'b0;
    for (int k = 1; k <= N_CPU; k++) begin
      int s;
      logic [CW-1:0] c;
      s = int'(last_q) + k;
      if (s >= N_CPU) s = s - N_CPU;
      c = CW'(s);
      if (!rr_found && dmask_q[c]) begin
        rr_found  = 1'b1;
        rr_idx    = c;
        rr_oh     = '0;
        rr_oh[c]  = 1'b1;
      end
    end
  end

  assign tgt_o  = exact ? last_oh : (mode_q ? rr_oh : dmask_q);
  assign elig_o = pend_q && !cfg_q.masked && (cfg_q.prio != '0) && !act_q && (|dmask_q);
  assign act_o  = act_q;

  assign vp_o  = {cfg_q.masked, act_q, 10'b0, cfg_q.prio, 8'b0, cfg_q.vec};
  assign dst_o = {mode_q, sense_q, {(30-N_CPU){1'b0}}, dmask_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.masked <= VP_RST[VP_MASK_BIT];
      cfg_q.prio   <= VP_RST[PRIO_LSB +: PRIO_W];
      cfg_q.vec    <= VP_RST[VEC_W-1:0];
      mode_q       <= DST_RST[DST_MODE_BIT];
      sense_q      <= DST_RST[DST_SENSE_BIT];
      dmask_q      <= DST_RST[N_CPU-1:0];
    end else begin
      if (we_vp_i) begin
        cfg_q.masked <= wdata_i[VP_MASK_BIT];
        cfg_q.prio   <= wdata_i[PRIO_LSB +: PRIO_W];
        cfg_q.vec    <= wdata_i[VEC_W-1:0];
      end
      if (we_dst_i) begin
        mode_q  <= wdata_i[DST_MODE_BIT];
        sense_q <= wdata_i[DST_SENSE_BIT];
        dmask_q <= wdata_i[N_CPU-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      last_q <= '0;
    end else begin
      irq_q <= irq_i;
      if (sense_q) pend_q <= irq_i;
      else if (irq_i && !irq_q) pend_q <= 1'b1;
      else if (grant_i) pend_q <= 1'b0;

      if (grant_i) act_q <= 1'b1;
      else if (sense_q && !irq_i) act_q <= 1'b0;
      else if (!sense_q && ack_i) act_q <= 1'b0;

      if (grant_i && !exact && mode_q && rr_found) last_q <= rr_idx;
    end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 8,
  localparam int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic          any_o,
  output logic [SW-1:0] idx_o
);
  // lowest set bit wins
  assign gnt_o = req_i & (~req_i + N'(1));
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (gnt_o[i]) idx_o = idx_o | SW'(i);
  end
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top #(
  parameter int          N_SRC   = 8,
  parameter int          N_CPU   = 4,
  parameter logic [31:0] VP_RST  = 32'h8000_0000,
  parameter logic [31:0] DST_RST = 32'h0000_0001,
  localparam int         SW      = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int         AW      = SW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_we_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             ack_i,
  input  logic [SW-1:0]    ack_src_i,
  output logic             dlv_valid_o,
  output logic [N_CPU-1:0] dlv_cpu_o,
  output logic [SW-1:0]    dlv_src_o
);
  logic [SW-1:0]    sel_src;
  logic             sel_dst;
  logic [31:0]      vp_rd  [N_SRC];
  logic [31:0]      dst_rd [N_SRC];
  logic [N_CPU-1:0] tgt    [N_SRC];
  logic [N_SRC-1:0] elig, gnt, act_vec;
  logic             any;
  logic [SW-1:0]    pick_idx;

  assign sel_src = bus_addr_i[AW-1:1];
  assign sel_dst = bus_addr_i[0];

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    irq_src_slot #(
      .N_CPU  (N_CPU),
      .VP_RST (VP_RST),
      .DST_RST(DST_RST)
    ) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .irq_i   (irq_i[g]),
      .we_vp_i (bus_we_i && !sel_dst && (sel_src == SW'(g))),
      .we_dst_i(bus_we_i &&  sel_dst && (sel_src == SW'(g))),
      .wdata_i (bus_wdata_i),
      .grant_i (gnt[g]),
      .ack_i   (ack_i && (ack_src_i == SW'(g))),
      .vp_o    (vp_rd[g]),
      .dst_o   (dst_rd[g]),
      .elig_o  (elig[g]),
      .act_o   (act_vec[g]),
      .tgt_o   (tgt[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (int'(sel_src) < N_SRC)
      bus_rdata_o = sel_dst ? dst_rd[sel_src] : vp_rd[sel_src];
  end

  irq_pick #(.N(N_SRC)) u_pick (
    .req_i(elig),
    .gnt_o(gnt),
    .any_o(any),
    .idx_o(pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dlv_valid_o <= 1'b0;
      dlv_cpu_o   <= '0;
      dlv_src_o   <= '0;
    end else begin
      dlv_valid_o <= any;
      dlv_cpu_o   <= any ? tgt[pick_idx] : '0;
      dlv_src_o   <= pick_idx;
    end
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int  N_SRC = 8,
  parameter int  N_CPU = 4,
  localparam int SW    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             dlv_valid_i,
  input logic [N_CPU-1:0] dlv_cpu_i,
  input logic [SW-1:0]    dlv_src_i,
  input logic [N_SRC-1:0] act_vec_i
);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dlv_valid_i |-> (dlv_cpu_i == '0));

  assert_no_empty_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_i |-> (dlv_cpu_i != '0));

  assert_active_after_delivery_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv_valid_i |-> act_vec_i[dlv_src_i]);

  assert_no_back_to_back_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_i && $past(dlv_valid_i)) |-> (dlv_src_i != $past(dlv_src_i)));
endmodule

bind irq_route_top irq_route_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dlv_valid_i(dlv_valid_o),
  .dlv_cpu_i  (dlv_cpu_o),
  .dlv_src_i  (dlv_src_o),
  .act_vec_i  (act_vec)
);

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb;
  localparam int N_SRC = 8;
  localparam int N_CPU = 4;
  localparam int SW = 3;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N_SRC-1:0] irq = '0;
  logic ack = 1'b0;
  logic [SW-1:0] ack_src = '0;
  logic dlv_valid;
  logic [N_CPU-1:0] dlv_cpu;
  logic [SW-1:0] dlv_src;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_route_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_i(irq),
    .ack_i(ack), .ack_src_i(ack_src), .dlv_valid_o(dlv_valid),
    .dlv_cpu_o(dlv_cpu), .dlv_src_o(dlv_src)
  );

  function automatic logic [31:0] vp_expect(logic act, logic [31:0] w);
    return (w & 32'h800F_00FF) | {1'b0, act, 30'b0};
  endfunction

  function automatic logic [31:0] dst_expect(logic [31:0] w);
    return w & 32'hC000_000F;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int src, bit sel, logic [31:0] d);
    bus_addr = AW'(src * 2 + int'(sel));
    bus_wdata = d;
    bus_we = 1'b1;
    tick(1);
    bus_we = 1'b0;
  endtask

  task automatic rd(int src, bit sel, output logic [31:0] d);
    bus_addr = AW'(src * 2 + int'(sel));
    #0.5;
    d = bus_rdata;
  endtask

  task automatic chk32(logic [31:0] act, logic [31:0] exp, string tag);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic chk_dlv(bit v, logic [N_CPU-1:0] cpu, int src, string tag);
    vectors++;
    if (dlv_valid !== v || dlv_cpu !== cpu || (v && dlv_src !== SW'(src))) begin
      errors++;
      $display("FAIL %s: actual v=%0b cpu=%b src=%0d expected v=%0b cpu=%b src=%0d",
               tag, dlv_valid, dlv_cpu, dlv_src, v, cpu, v ? src : 0);
    end
  endtask

  task automatic do_ack(int src);
    ack_src = SW'(src);
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  // edge pulse on source 4, expect delivery two edges after the rise
  task automatic pulse4(logic [N_CPU-1:0] cpu, string tag);
    irq[4] = 1'b1;
    tick(1);
    irq[4] = 1'b0;
    tick(1);
    chk_dlv(1'b1, cpu, 4, tag);
    tick(1);
    chk_dlv(1'b0, '0, 0, {tag, " no repeat"});
    do_ack(4);
  endtask

  initial begin
    logic [31:0] d;
    tick(2);
    rst_n = 1'b1;
    tick(1);

    // R3 reset state
    chk_dlv(1'b0, '0, 0, "R3 idle after reset");
    rd(0, 1'b0, d); chk32(d, 32'h8000_0000, "R3 vp reset");
    rd(5, 1'b1, d); chk32(d, 32'h0000_0001, "R3 dst reset");

    // R1/R2 random register traffic, all inputs low so activity stays 0
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 40; i++) begin
      int s;
      bit sel;
      logic [31:0] w;
      s = int'($urandom_range(N_SRC - 1, 0));
      sel = 1'($urandom_range(1, 0));
      w = $urandom;
      wr(s, sel, w);
      rd(s, sel, d);
      if (sel) chk32(d, dst_expect(w), "R2 dst readback");
      else     chk32(d, vp_expect(1'b0, w), "R1 vp readback");
    end
    for (int s = 0; s < N_SRC; s++) begin
      wr(s, 1'b0, 32'h8000_0000);
      wr(s, 1'b1, 32'h0000_0001);
    end
    chk_dlv(1'b0, '0, 0, "R4 quiet after reinit");

    // R6/R9 level source 2, directed to CPUs 1,2
    wr(2, 1'b1, 32'h4000_0006);
    wr(2, 1'b0, 32'h0005_0042);
    irq[2] = 1'b1;
    tick(1);
    chk_dlv(1'b0, '0, 0, "R11 not yet after one edge");
    tick(1);
    chk_dlv(1'b1, 4'b0110, 2, "R9 directed level delivery");
    tick(1);
    chk_dlv(1'b0, '0, 0, "R5 active blocks redelivery");
    rd(2, 1'b0, d); chk32(d, 32'h4005_0042, "R1 activity visible");
    wr(2, 1'b0, 32'h0005_0042);
    rd(2, 1'b0, d); chk32(d, 32'h4005_0042, "R1 activity not writable");
    irq[2] = 1'b0;
    tick(1);
    rd(2, 1'b0, d); chk32(d, 32'h0005_0042, "R6 deassert clears activity");
    irq[2] = 1'b1;
    tick(2);
    chk_dlv(1'b1, 4'b0110, 2, "R6 reassert delivers again");
    irq[2] = 1'b0;
    tick(2);

    // R4 blocking conditions on level source 3
    wr(3, 1'b1, 32'h4000_0001);
    wr(3, 1'b0, 32'h8005_0033);
    irq[3] = 1'b1;
    tick(2); chk_dlv(1'b0, '0, 0, "R4 masked");
    tick(1); chk_dlv(1'b0, '0, 0, "R4 masked later");
    wr(3, 1'b0, 32'h0000_0033);
    tick(2); chk_dlv(1'b0, '0, 0, "R4 priority zero");
    wr(3, 1'b1, 32'h4000_0000);
    wr(3, 1'b0, 32'h0005_0033);
    tick(2); chk_dlv(1'b0, '0, 0, "R4 empty mask");
    wr(3, 1'b1, 32'h4000_0001);
    tick(1); chk_dlv(1'b1, 4'b0001, 3, "R4 R11 delivered one edge after write");
    irq[3] = 1'b0;
    tick(2);

    // R10/R7 edge source 4, distributed over all CPUs, last served starts at 0
    wr(4, 1'b1, 32'h8000_000F);
    wr(4, 1'b0, 32'h0003_0044);
    pulse4(4'b0010, "R10 rr cpu1");
    pulse4(4'b0100, "R10 rr cpu2");
    pulse4(4'b1000, "R10 rr cpu3");
    pulse4(4'b0001, "R10 rr wrap cpu0");
    // held-high edge input: one delivery only
    irq[4] = 1'b1;
    tick(2);
    chk_dlv(1'b1, 4'b0010, 4, "R7 edge held high delivers");
    do_ack(4);
    tick(3);
    chk_dlv(1'b0, '0, 0, "R7 no redelivery while held");
    rd(4, 1'b0, d); chk32(d, 32'h0003_0044, "R5 ack clears activity");
    irq[4] = 1'b0;
    tick(1);
    // last served is now 1; sparse mask 1010
    wr(4, 1'b1, 32'h8000_000A);
    pulse4(4'b1000, "R10 rr skips unselected");
    pulse4(4'b0010, "R10 rr wraps to cpu1");
    wr(4, 1'b1, 32'h8000_0002);
    pulse4(4'b0010, "R8 exact last cpu");
    wr(4, 1'b1, 32'h0000_000F);
    pulse4(4'b1111, "R9 directed to all");

    // R11 arbitration between two level sources
    wr(5, 1'b1, 32'h4000_0004);
    wr(5, 1'b0, 32'h0002_0055);
    wr(6, 1'b1, 32'h4000_0001);
    wr(6, 1'b0, 32'h000F_0066);
    irq[5] = 1'b1;
    irq[6] = 1'b1;
    tick(2);
    chk_dlv(1'b1, 4'b0100, 5, "R11 lower source first");
    tick(1);
    chk_dlv(1'b1, 4'b0001, 6, "R11 R8 second source next");
    tick(1);
    chk_dlv(1'b0, '0, 0, "R11 idle after both");
    irq[5] = 1'b0;
    irq[6] = 1'b0;
    tick(2);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule